// File: doc/BRIEF.md
# Word-Parallel CRC-16 Packet Checker

This block computes a CRC-16 over packets that reach it one 32-bit word per accepted strobe, with a word count that changes from one packet to the next. The CRC uses the generator x^16 + x^12 + x^5 + 1 (0x1021). It runs MSB first, with no bit reflection and no final inversion. The register is preset to 16'hFFFF when a packet opens. A full 32-bit word is folded into the CRC in one clock through fixed XOR equations. These equations are derived at elaboration from the polynomial, so the checker keeps up with a source such as a FIFO that offers words with idle gaps between them.

A word marked start-of-packet opens a packet, and a word marked end-of-packet closes it. On the cycle after the closing word, the block raises a one-cycle result strobe, and the running CRC output then holds the final value. Packets shorter than the configured minimum (4 words) are flagged during the same cycle. The control is a three-state machine. `S_IDLE` means no packet is open. `S_BODY` means a packet is open. `S_REPORT` is the single result cycle. The transitions are:

- *open*: `S_IDLE`/`S_REPORT` to `S_BODY` on a start word without end.
- *single*: `S_IDLE`/`S_REPORT` to `S_REPORT` on a start word that also ends.
- *close*: `S_BODY` to `S_REPORT` on an end word.
- *restart*: `S_BODY` to `S_BODY` on a new start word.
- *drain*: `S_REPORT` to `S_IDLE` otherwise.

Top module: `crc16_word_checker`

## Requirements
- R1: After reset, `crc_out` is 16'hFFFF and `crc_valid` and `len_err` are 0.
- R2: A valid word with `word_sop`=1 loads `crc_out` with the CRC of that word computed from the preset 16'hFFFF, whatever the previous CRC value was.
- R3: Each following valid word of an open packet updates the CRC with polynomial 0x1021, feeding data bit 31 first down to bit 0, with no reflection and no final XOR.
- R4: All 32 bits of a word are absorbed in one clock: `crc_out` shows the updated value on the first clock edge after the word is accepted.
- R5: On any cycle with `word_valid`=0, `crc_out` keeps its value, whatever the other inputs do.
- R6: After a valid word with `word_eop`=1 that belongs to a packet, `crc_valid` is 1 for exactly the following cycle. `crc_out` then keeps the final CRC until the next accepted word.
- R7: `len_err` is 1 together with `crc_valid` when the packet (counted from its start word to its end word inclusive) had fewer than 4 words. It is 0 for 4 or more words.
- R8: A valid word without `word_sop` while no packet is open is ignored: `crc_out` is unchanged and no `crc_valid` follows, even if `word_eop` is set.
- R9: A start word arriving inside an open packet abandons that packet without a result, re-presets the CRC and restarts the word count.
- R10: Packet length is set at run time only by the markers. A packet of hundreds of words yields a correct CRC and no `len_err`.
- R11: A single word carrying both `word_sop` and `word_eop` is a complete 1-word packet, reported with `crc_valid` and `len_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_data | input | 32 | Packet data word |
| word_valid | input | 1 | Word strobe; data and markers qualify only when high |
| word_sop | input | 1 | Word is the first of a packet |
| word_eop | input | 1 | Word is the last of a packet |
| crc_out | output | 16 | Running CRC; final value while `crc_valid` is high |
| crc_valid | output | 1 | One-cycle result strobe after the end word |
| len_err | output | 1 | Packet shorter than the minimum, valid with `crc_valid` |

## Verification
On every cycle, the embedded assertions check several properties:

- the CRC holds while no word is offered;
- every result strobe follows an accepted end word;
- a stray word in idle leaves the machine idle, and a start word always opens or reports a packet;
- a single start-and-end word raises the length flag;
- the saturating length counter stays within bound.

The CRC values cannot be checked by a property, and neither can the exact length threshold or the restart behaviour after an abandoned packet. The bench scenarios cover these against a bit-serial model: sweeps of packet length across the threshold, a single-bit sweep over every data position, gaps, stray words, restarts and a long packet.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int unsigned CRC_BITS  = 16;
    localparam int unsigned WORD_BITS = 32;
    localparam logic [15:0] POLY_0x1021 = 16'h1021;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_BODY   = 2'd1,
        S_REPORT = 2'd2
    } pkt_state_e;

endpackage

// File: rtl/crc16_word_update.sv
module crc16_word_update #(
    parameter int unsigned          CRC_W  = 16,
    parameter int unsigned          DATA_W = 32,
    parameter logic [CRC_W-1:0]     POLY   = 16'h1021
) (
    input  logic [CRC_W-1:0]  seed,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  next
);

    localparam int unsigned IN_W = CRC_W + DATA_W;

    // Serial definition used only at elaboration to derive the XOR masks.
    function automatic logic [CRC_W-1:0] serial_fold(
        input logic [CRC_W-1:0]  c_in,
        input logic [DATA_W-1:0] d_in
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = c_in;
        for (int b = DATA_W - 1; b >= 0; b--) begin
            fb = c[CRC_W-1] ^ d_in[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    // Mask of the inputs {seed, word} that feed output bit 'row'.
    function automatic logic [IN_W-1:0] row_mask(input int row);
        logic [IN_W-1:0]  unit;
        logic [IN_W-1:0]  m;
        logic [CRC_W-1:0] r;
        m = '0;
        for (int j = 0; j < int'(IN_W); j++) begin
            unit    = '0;
            unit[j] = 1'b1;
            r       = serial_fold(unit[IN_W-1:DATA_W], unit[DATA_W-1:0]);
            m[j]    = r[row];
        end
        return m;
    endfunction

    logic [IN_W-1:0] joined;
    assign joined = {seed, word};

    for (genvar g = 0; g < int'(CRC_W); g++) begin : g_eq
        localparam logic [IN_W-1:0] MASK = row_mask(g);
        assign next[g] = ^(joined & MASK);
    end

endmodule

// File: rtl/crc16_len_counter.sv
module crc16_len_counter #(
    parameter int unsigned MIN_WORDS = 4,
    parameter int unsigned CNT_W     = $clog2(MIN_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MIN_WORDS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(1);
        end else if (step && (cnt_q < CNT_CAP)) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R10: saturating count never passes the threshold, any packet length
    assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_CAP);

endmodule

// File: rtl/crc16_pkt_fsm.sv
module crc16_pkt_fsm
    import crc16_pkg::*;
#(
    parameter int unsigned MIN_WORDS = 4,
    parameter int unsigned CNT_W     = $clog2(MIN_WORDS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic             word_sop,
    input  logic             word_eop,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             start_pkt,
    output logic             step_pkt,
    output logic             crc_valid,
    output logic             len_err
);

    pkt_state_e state_q, state_d;
    logic       short_q;
    logic       short_now;
    logic       closing;

    assign start_pkt = word_valid && word_sop;
    assign step_pkt  = word_valid && !word_sop && (state_q == S_BODY);
    assign closing   = word_eop && (start_pkt || step_pkt);
    assign short_now = start_pkt ? (MIN_WORDS > 1)
                                 : ((int'(cnt_q) + 1) < int'(MIN_WORDS));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_REPORT: begin
                if (start_pkt) state_d = word_eop ? S_REPORT : S_BODY;
                else           state_d = S_IDLE;
            end
            S_BODY: begin
                if (word_valid) state_d = word_eop ? S_REPORT : S_BODY;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (closing) short_q <= short_now;
        end
    end

    always_comb begin
        crc_valid = (state_q == S_REPORT);
        len_err   = (state_q == S_REPORT) && short_q;
    end

    // R6: a result strobe is always preceded by an accepted end word
    assert_valid_after_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_valid |-> $past(word_valid && word_eop));

    // R8: a stray non-start word while idle keeps the machine idle
    assert_stray_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && word_valid && !word_sop) |=> (state_q == S_IDLE));

    // R9: a start word without end always leaves a packet open
    assert_sop_opens_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_sop && !word_eop) |=> (state_q == S_BODY));

endmodule

// File: rtl/crc16_word_checker.sv
module crc16_word_checker
    import crc16_pkg::*;
#(
    parameter int unsigned      CRC_W     = CRC_BITS,
    parameter int unsigned      DATA_W    = WORD_BITS,
    parameter logic [CRC_W-1:0] POLY      = POLY_0x1021,
    parameter logic [CRC_W-1:0] INIT      = CRC_PRESET,
    parameter int unsigned      MIN_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] word_data,
    input  logic              word_valid,
    input  logic              word_sop,
    input  logic              word_eop,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_valid,
    output logic              len_err
);

    localparam int unsigned CNT_W = $clog2(MIN_WORDS + 1);

    logic             start_pkt;
    logic             step_pkt;
    logic [CNT_W-1:0] cnt_q;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] crc_next;

    crc16_pkt_fsm #(
        .MIN_WORDS (MIN_WORDS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word_sop   (word_sop),
        .word_eop   (word_eop),
        .cnt_q      (cnt_q),
        .start_pkt  (start_pkt),
        .step_pkt   (step_pkt),
        .crc_valid  (crc_valid),
        .len_err    (len_err)
    );

    crc16_len_counter #(
        .MIN_WORDS (MIN_WORDS),
        .CNT_W     (CNT_W)
    ) u_len (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_pkt),
        .step  (step_pkt),
        .cnt_q (cnt_q)
    );

    assign seed = start_pkt ? INIT : crc_q;

    crc16_word_update #(
        .CRC_W  (CRC_W),
        .DATA_W (DATA_W),
        .POLY   (POLY)
    ) u_upd (
        .seed (seed),
        .word (word_data),
        .next (crc_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                     crc_q <= INIT;
        else if (start_pkt || step_pkt) crc_q <= crc_next;
    end

    assign crc_out = crc_q;

    // R5: no strobe, no change
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |=> $stable(crc_out));

    // R11: a start-and-end word is a one-word packet, always flagged short
    assert_single_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_sop && word_eop) |=> (crc_valid && len_err));

endmodule

// File: tb/test_crc16_word_checker.sv
module test_crc16_word_checker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_sop;
    logic        word_eop;
    logic [15:0] crc_out;
    logic        crc_valid;
    logic        len_err;

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [15:0] model_crc;

    always #2 clk = ~clk;

    crc16_word_checker i_crc16_word_checker (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_sop   (word_sop),
        .word_eop   (word_eop),
        .crc_out    (crc_out),
        .crc_valid  (crc_valid),
        .len_err    (len_err)
    );

    // Bit-serial reference: MSB first, polynomial 0x1021
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r;
        r = c;
        for (int b = 31; b >= 0; b--)
            r = {r[14:0], 1'b0} ^ ({16{r[15] ^ w[b]}} & 16'h1021);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Offer one word for one cycle; return at the next falling edge (outputs settled)
    task automatic put_word(input logic [31:0] w, input logic s, input logic e);
        @(negedge clk);
        word_data = w; word_valid = 1'b1; word_sop = s; word_eop = e;
        @(negedge clk);
        word_valid = 1'b0; word_sop = 1'b0; word_eop = 1'b0; word_data = ~w;
    endtask

    task automatic feed(input logic [31:0] w, input logic s, input logic e, input string tag);
        put_word(w, s, e);
        model_crc = ref_crc(s ? 16'hFFFF : model_crc, w);
        check(tag, {16'h0, crc_out}, {16'h0, model_crc});
        if (!e) check("R6 no strobe mid-packet", {31'h0, crc_valid}, 32'h0);
    endtask

    task automatic finish_check(input int n);
        check("R6 strobe after end word", {31'h0, crc_valid}, 32'h1);
        check("R7 length flag", {31'h0, len_err}, {31'h0, (n < 4)});
        @(negedge clk);
        check("R6 strobe lasts one cycle", {31'h0, crc_valid}, 32'h0);
        check("R6 final CRC held", {16'h0, crc_out}, {16'h0, model_crc});
    endtask

    task automatic run_pkt(input int n, input logic [31:0] base, input string tag);
        for (int k = 0; k < n; k++)
            feed(base ^ (32'(k) * 32'h9E3779B9), (k == 0), (k == n - 1),
                 (k == 0) ? "R2 preset on start" : tag);
        finish_check(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; word_valid = 1'b0; word_sop = 1'b0; word_eop = 1'b0;
        word_data = 32'h0;
        repeat (3) @(negedge clk);
        check("R1 reset crc", {16'h0, crc_out}, 32'h0000FFFF);
        check("R1 reset valid", {31'h0, crc_valid}, 32'h0);
        check("R1 reset len_err", {31'h0, len_err}, 32'h0);
        rst_n = 1'b1;

        // R7 / R11 / R3: length sweep across the threshold, several patterns
        for (int n = 1; n <= 8; n++) begin
            run_pkt(n, 32'h0000_0000, "R3 word update");
            run_pkt(n, 32'hFFFF_FFFF, "R3 word update");
            run_pkt(n, 32'hA5A5_3C3C, "R3 word update");
        end

        // R4: every data bit position in a one-word packet
        for (int b = 0; b < 32; b++) begin
            feed(32'h1 << b, 1'b1, 1'b1, "R4 single-clock word");
            finish_check(1);
        end

        // R10: long packet
        run_pkt(300, 32'h1234_5678, "R10 long packet");

        // R5: gaps with changing inputs inside a packet
        feed(32'hCAFE_0001, 1'b1, 1'b0, "R2 preset on start");
        feed(32'hCAFE_0002, 1'b0, 1'b0, "R3 word update");
        for (int g = 0; g < 5; g++) begin
            @(negedge clk);
            word_data = 32'(g) * 32'h0101_0101; word_sop = g[0]; word_eop = g[1];
            @(negedge clk);
            check("R5 hold without strobe", {16'h0, crc_out}, {16'h0, model_crc});
        end
        word_sop = 1'b0; word_eop = 1'b0;
        feed(32'hCAFE_0003, 1'b0, 1'b0, "R5 resume after gap");
        feed(32'hCAFE_0004, 1'b0, 1'b1, "R5 resume after gap");
        finish_check(4);

        // R8: stray words outside a packet
        put_word(32'hDEAD_BEEF, 1'b0, 1'b0);
        check("R8 stray word ignored", {16'h0, crc_out}, {16'h0, model_crc});
        check("R8 stray no strobe", {31'h0, crc_valid}, 32'h0);
        put_word(32'hDEAD_BEE0, 1'b0, 1'b1);
        check("R8 stray end ignored", {16'h0, crc_out}, {16'h0, model_crc});
        check("R8 stray end no strobe", {31'h0, crc_valid}, 32'h0);

        // R9: restart inside an open packet; count restarts (2 words -> short)
        feed(32'h0BAD_0001, 1'b1, 1'b0, "R2 preset on start");
        feed(32'h0BAD_0002, 1'b0, 1'b0, "R3 word update");
        feed(32'h0BAD_0003, 1'b0, 1'b0, "R3 word update");
        feed(32'h600D_0001, 1'b1, 1'b0, "R9 restart presets");
        feed(32'h600D_0002, 1'b0, 1'b1, "R9 restart update");
        check("R9 restarted count flags short", {31'h0, len_err}, 32'h1);
        finish_check(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule